// File: doc/BRIEF.md
# Single-Wire Configuration Slave

This block lets a bus master load and read back a small bank of configuration bytes over one open-drain data line. It samples the line with a fast system clock and, after a synchroniser, measures every low period. A long enough low counts as a bus reset. The slave answers it with a presence pulse of its own, then takes one command byte. Depending on that byte it stores the following data bytes, returns the current bytes, raises a one-cycle commit strobe toward the nonvolatile storage, or reloads the bytes from that storage.

All timing is set in microseconds and turned into clock cycles with `CLK_PER_US`. Below, T_RST, T_PW, T_PL, T_SMP and T_HLD are the reset, presence-wait, presence-length, sample-point and read-hold values in microseconds multiplied by `CLK_PER_US`. "Line" means the bus level after the `SYNC_STAGES`-flop synchroniser. The bus is the wired-AND of the master's pull-down and `dq_pull`.

Top module: `owcfg_slave`

## Requirements
- R1: After reset, `dq_pull` is 0, `commit_stb` is 0 and `cfg_val` equals `RESET_VAL`.
- R2: A rising edge of the line that follows at least T_RST consecutive low cycles is a bus reset. A shorter low is not.
- R3: After a bus reset, `dq_pull` rises T_PW cycles after the rising edge is seen. It stays high for exactly T_PL cycles and is never high for more than T_PL consecutive cycles.
- R4: In a write slot, the bit is the line level T_SMP cycles after the falling edge is seen (low = 0).
- R5: Every byte, whether a command or data, moves least significant bit first.
- R6: Command 0x01 stores the next `NUM_REGS` bytes in order. Byte k goes to `cfg_val[8k+7:8k]` when its eighth bit is sampled. `cfg_val` never changes while `dq_pull` is high.
- R7: Command 0x02 sends the `NUM_REGS` bytes from byte 0 upward. For a 0 bit, `dq_pull` is high for T_HLD cycles from the seen falling edge. For a 1 bit it stays low.
- R8: Command 0x48 gives a single-cycle `commit_stb`. While the strobe is high, `cfg_val` does not change and `dq_pull` is low.
- R9: Command 0xB8 loads `cfg_val` from `store_val`.
- R10: After any other command byte, slots are ignored until the next bus reset. `cfg_val` keeps its value and read slots return 1.
- R11: A bus reset at any point aborts the transaction and brings a new presence pulse. A partly received byte is dropped, and bytes already completed stay stored.
- R12: Once a command's last byte is done, further slots are ignored until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dq_in | input | 1 | Level sensed on the shared data line |
| dq_pull | output | 1 | Enable for the line pull-down |
| store_val | input | NUM_REGS*8 | Contents of the nonvolatile storage, used on recall |
| cfg_val | output | NUM_REGS*8 | Current configuration bytes, byte 0 in the low bits |
| commit_stb | output | 1 | One-cycle request to write `cfg_val` to storage |

## Verification
On every cycle, the bound checker enforces the upper bound on the length of any pull-down run and that the configuration never changes while the slave pulls the line. It also checks that the commit strobe lasts one cycle and arrives with a quiet line and steady data. Only the bench's scenarios can show the rest: where the presence pulse falls after a reset, where the write-slot sample point lies against low times just inside and just outside it, and the bit order. The same holds for command decoding, the silence after an unknown command or a finished transfer, and a reset that cuts into the middle of a byte.

// File: rtl/owcfg_pkg.sv
package owcfg_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_W  = $clog2(BYTE_W);

   localparam logic [BYTE_W-1:0] OP_STORE  = 8'h01;
   localparam logic [BYTE_W-1:0] OP_FETCH  = 8'h02;
   localparam logic [BYTE_W-1:0] OP_COMMIT = 8'h48;
   localparam logic [BYTE_W-1:0] OP_RECALL = 8'hB8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWAIT,
      ST_PDRV,
      ST_CMD,
      ST_WR,
      ST_RD,
      ST_DONE
   } ow_state_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/owcfg_sync.sv
module owcfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/owcfg_linemon.sv
module owcfg_linemon #(
   parameter int RST_T = 960
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_s,
   output logic fall,
   output logic rst_det
);

   localparam int             LW     = $clog2(RST_T + 1);
   localparam logic [LW-1:0]  LO_SAT = LW'(RST_T);

   logic          prev_s;
   logic [LW-1:0] lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_s <= 1'b1;
         lo_cnt <= '0;
      end else begin
         prev_s <= line_s;
         if (line_s) begin
            lo_cnt <= '0;
         end else if (lo_cnt != LO_SAT) begin
            lo_cnt <= lo_cnt + 1'b1;
         end
      end
   end

   assign fall    = prev_s & ~line_s;
   assign rst_det = ~prev_s & line_s & (lo_cnt == LO_SAT);

endmodule

// File: rtl/owcfg_ctrl.sv
module owcfg_ctrl
   import owcfg_pkg::*;
#(
   parameter int                          NUM_REGS  = 2,
   parameter logic [NUM_REGS*BYTE_W-1:0]  RESET_VAL = '1,
   parameter int                          PW_T      = 1500,
   parameter int                          PL_T      = 6000,
   parameter int                          SMP_T     = 1500,
   parameter int                          HLD_T     = 1500
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         line_s,
   input  logic                         fall,
   input  logic                         rst_det,
   input  logic [NUM_REGS*BYTE_W-1:0]   store_val,
   output logic                         pull,
   output logic [NUM_REGS*BYTE_W-1:0]   cfg_val,
   output logic                         commit_stb
);

   localparam int REG_W = NUM_REGS * BYTE_W;
   localparam int MAX_T = max4(PW_T, PL_T, SMP_T, HLD_T);
   localparam int TW    = $clog2(MAX_T) + 1;
   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   localparam logic [TW-1:0]    PW_END   = TW'(PW_T - 1);
   localparam logic [TW-1:0]    PL_END   = TW'(PL_T - 1);
   localparam logic [TW-1:0]    SMP_END  = TW'(SMP_T - 1);
   localparam logic [TW-1:0]    HLD_END  = TW'(HLD_T - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_REGS - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

   ow_state_e         st;
   logic [TW-1:0]     tmr;
   logic              in_slot;
   logic              drv0;
   logic [BIT_W-1:0]  bit_i;
   logic [IDX_W-1:0]  idx;
   logic [BYTE_W-1:0] shreg;
   logic [REG_W-1:0]  regs;
   logic [BYTE_W-1:0] nxt_byte;
   logic              tx_bit;
   logic              slot_st;

   assign nxt_byte = {line_s, shreg[BYTE_W-1:1]};
   assign tx_bit   = regs[int'(idx) * BYTE_W + int'(bit_i)];
   assign slot_st  = (st == ST_CMD) || (st == ST_WR) || (st == ST_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         tmr        <= '0;
         in_slot    <= 1'b0;
         drv0       <= 1'b0;
         bit_i      <= '0;
         idx        <= '0;
         shreg      <= '0;
         regs       <= RESET_VAL;
         commit_stb <= 1'b0;
      end else begin
         commit_stb <= 1'b0;
         if (rst_det) begin
            st      <= ST_PWAIT;
            tmr     <= '0;
            in_slot <= 1'b0;
            drv0    <= 1'b0;
            bit_i   <= '0;
            idx     <= '0;
         end else if (st == ST_PWAIT) begin
            if (tmr == PW_END) begin
               st  <= ST_PDRV;
               tmr <= '0;
            end else begin
               tmr <= tmr + 1'b1;
            end
         end else if (st == ST_PDRV) begin
            if (tmr == PL_END) begin
               st      <= ST_CMD;
               tmr     <= '0;
               bit_i   <= '0;
               in_slot <= 1'b0;
            end else begin
               tmr <= tmr + 1'b1;
            end
         end else if (slot_st) begin
            if (!in_slot) begin
               if (fall) begin
                  in_slot <= 1'b1;
                  tmr     <= '0;
                  drv0    <= (st == ST_RD) && !tx_bit;
               end
            end else if (st == ST_RD) begin
               if (tmr == HLD_END) begin
                  in_slot <= 1'b0;
                  drv0    <= 1'b0;
                  bit_i   <= bit_i + 1'b1;
                  if (bit_i == BIT_LAST) begin
                     if (idx == IDX_LAST) st <= ST_DONE;
                     else                 idx <= idx + 1'b1;
                  end
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end else begin
               if (tmr == SMP_END) begin
                  in_slot <= 1'b0;
                  shreg   <= nxt_byte;
                  bit_i   <= bit_i + 1'b1;
                  if (bit_i == BIT_LAST) begin
                     if (st == ST_CMD) begin
                        idx <= '0;
                        case (nxt_byte)
                           OP_STORE:  st <= ST_WR;
                           OP_FETCH:  st <= ST_RD;
                           OP_COMMIT: begin
                              commit_stb <= 1'b1;
                              st         <= ST_DONE;
                           end
                           OP_RECALL: begin
                              regs <= store_val;
                              st   <= ST_DONE;
                           end
                           default:   st <= ST_DONE;
                        endcase
                     end else begin
                        regs[int'(idx) * BYTE_W +: BYTE_W] <= nxt_byte;
                        if (idx == IDX_LAST) st <= ST_DONE;
                        else                 idx <= idx + 1'b1;
                     end
                  end
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
         end
      end
   end

   assign pull    = (st == ST_PDRV) | drv0;
   assign cfg_val = regs;

endmodule

// File: rtl/owcfg_slave.sv
module owcfg_slave
   import owcfg_pkg::*;
#(
   parameter int                          CLK_PER_US  = 50,
   parameter int                          RST_US      = 480,
   parameter int                          PW_US       = 30,
   parameter int                          PL_US       = 120,
   parameter int                          SMP_US      = 30,
   parameter int                          HLD_US      = 30,
   parameter int                          SYNC_STAGES = 2,
   parameter int                          NUM_REGS    = 2,
   parameter logic [NUM_REGS*BYTE_W-1:0]  RESET_VAL   = '1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        dq_in,
   output logic                        dq_pull,
   input  logic [NUM_REGS*BYTE_W-1:0]  store_val,
   output logic [NUM_REGS*BYTE_W-1:0]  cfg_val,
   output logic                        commit_stb
);

   localparam int RST_T = RST_US * CLK_PER_US;
   localparam int PW_T  = PW_US  * CLK_PER_US;
   localparam int PL_T  = PL_US  * CLK_PER_US;
   localparam int SMP_T = SMP_US * CLK_PER_US;
   localparam int HLD_T = HLD_US * CLK_PER_US;

   generate
      if (NUM_REGS < 1 || SYNC_STAGES < 1 || CLK_PER_US < 1) begin : g_bad_size
         $error("owcfg_slave: NUM_REGS, SYNC_STAGES and CLK_PER_US must be at least 1");
      end
      if (PW_US < 1 || PL_US < 1 || SMP_US < 1 || HLD_US < 1) begin : g_bad_time
         $error("owcfg_slave: every timing value must be at least 1 us");
      end
      if (RST_US <= PW_US + PL_US) begin : g_bad_rst
         $error("owcfg_slave: reset low time must exceed presence wait plus length");
      end
   endgenerate

   logic line_s;
   logic fall;
   logic rst_det;

   owcfg_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dq_in),
      .q     (line_s)
   );

   owcfg_linemon #(
      .RST_T (RST_T)
   ) u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_s  (line_s),
      .fall    (fall),
      .rst_det (rst_det)
   );

   owcfg_ctrl #(
      .NUM_REGS  (NUM_REGS),
      .RESET_VAL (RESET_VAL),
      .PW_T      (PW_T),
      .PL_T      (PL_T),
      .SMP_T     (SMP_T),
      .HLD_T     (HLD_T)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_s     (line_s),
      .fall       (fall),
      .rst_det    (rst_det),
      .store_val  (store_val),
      .pull       (dq_pull),
      .cfg_val    (cfg_val),
      .commit_stb (commit_stb)
   );

endmodule

// File: rtl/owcfg_chk.sv
module owcfg_chk #(
   parameter int PL_T  = 6000,
   parameter int REG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dq_pull,
   input logic             commit_stb,
   input logic [REG_W-1:0] cfg_val
);

   int unsigned pull_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pull_run <= 0;
      else if (dq_pull) pull_run <= pull_run + 1;
      else              pull_run <= 0;
   end

   p_pull_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pull_run <= PL_T);

   p_cfg_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_val != $past(cfg_val)) |-> !dq_pull);

   p_commit_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_stb |=> !commit_stb);

   p_commit_calm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_stb |-> (!dq_pull && $stable(cfg_val)));

endmodule

bind owcfg_slave owcfg_chk #(
   .PL_T  (PL_T),
   .REG_W (NUM_REGS * owcfg_pkg::BYTE_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .dq_pull    (dq_pull),
   .commit_stb (commit_stb),
   .cfg_val    (cfg_val)
);

// File: tb/owcfg_slave_tb_top.sv
`timescale 1ns/1ps
module owcfg_slave_tb_top;

   localparam int CPU   = 2;
   localparam int NR    = 2;
   localparam int SYNC  = 2;
   localparam int RST_T = 480 * CPU;
   localparam int PW_T  = 30 * CPU;
   localparam int PL_T  = 120 * CPU;
   localparam int SMP_T = 30 * CPU;
   localparam int HLD_T = 30 * CPU;
   localparam logic [15:0] RV = 16'hA55A;
   localparam logic [15:0] SV = 16'h3C81;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mst_low = 1'b0;
   logic        dq_pull;
   logic        commit_stb;
   logic [15:0] cfg_val;
   logic [15:0] store_val = SV;
   logic        bus;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   assign bus = !(mst_low || dq_pull);

   owcfg_slave #(
      .CLK_PER_US  (CPU),
      .SYNC_STAGES (SYNC),
      .NUM_REGS    (NR),
      .RESET_VAL   (RV)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .dq_in      (bus),
      .dq_pull    (dq_pull),
      .store_val  (store_val),
      .cfg_val    (cfg_val),
      .commit_stb (commit_stb)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   // Behavioural reference, updated on every rising edge
   bit          sq[$];
   int          prev_m, low_m, ph, t_m, ins_m, d0_m, bi_m, idx_m;
   logic [7:0]  sh_m;
   logic [15:0] cfg_m;
   bit          cm_m;

   always @(posedge clk) begin
      if (!rst_n) begin
         sq.delete();
         for (int i = 0; i < SYNC; i++) sq.push_back(1'b1);
         prev_m = 1; low_m = 0; ph = 0; t_m = 0; ins_m = 0; d0_m = 0;
         bi_m = 0; idx_m = 0; sh_m = '0; cfg_m = RV; cm_m = 0;
      end else begin
         bit cur, rst_ev, fall_ev;
         logic [7:0] nb;
         cur = sq.pop_front();
         sq.push_back(bus);
         cm_m    = 0;
         rst_ev  = cur && !prev_m && (low_m >= RST_T);
         fall_ev = prev_m && !cur;
         low_m   = cur ? 0 : low_m + 1;
         prev_m  = cur;
         if (rst_ev) begin
            ph = 1; t_m = 0; ins_m = 0; d0_m = 0; bi_m = 0; idx_m = 0;
         end else if (ph == 1) begin
            if (t_m == PW_T - 1) begin ph = 2; t_m = 0; end else t_m++;
         end else if (ph == 2) begin
            if (t_m == PL_T - 1) begin ph = 3; t_m = 0; bi_m = 0; ins_m = 0; end else t_m++;
         end else if (ph >= 3 && ph <= 5) begin
            if (!ins_m) begin
               if (fall_ev) begin
                  ins_m = 1; t_m = 0;
                  d0_m  = (ph == 5) && !cfg_m[idx_m*8 + bi_m];
               end
            end else if (ph == 5) begin
               if (t_m == HLD_T - 1) begin
                  ins_m = 0; d0_m = 0;
                  if (bi_m == 7) begin
                     bi_m = 0;
                     if (idx_m == NR - 1) ph = 6; else idx_m++;
                  end else bi_m++;
               end else t_m++;
            end else begin
               if (t_m == SMP_T - 1) begin
                  ins_m = 0;
                  nb    = {cur, sh_m[7:1]};
                  sh_m  = nb;
                  if (bi_m == 7) begin
                     bi_m = 0;
                     if (ph == 3) begin
                        idx_m = 0;
                        case (nb)
                           8'h01:   ph = 4;
                           8'h02:   ph = 5;
                           8'h48:   begin cm_m = 1; ph = 6; end
                           8'hB8:   begin cfg_m = store_val; ph = 6; end
                           default: ph = 6;
                        endcase
                     end else begin
                        cfg_m[idx_m*8 +: 8] = nb;
                        if (idx_m == NR - 1) ph = 6; else idx_m++;
                     end
                  end else bi_m++;
               end else t_m++;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R3/R7 model dq_pull", 32'(dq_pull), 32'((ph == 2) || (d0_m != 0)));
         check("R6/R9 model cfg_val", 32'(cfg_val), 32'(cfg_m));
         check("R8 model commit_stb", 32'(commit_stb), 32'(cm_m));
      end
   end

   int          n_commit = 0;
   logic [15:0] cfg_at_commit = '0;
   always @(posedge clk) begin
      if (rst_n && commit_stb) begin
         n_commit++;
         cfg_at_commit = cfg_val;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_reset(input int len, output int first, output int plen);
      first = -1; plen = 0;
      mst_low = 1'b1;
      wait_cyc(len);
      mst_low = 1'b0;
      for (int k = 1; k <= 700; k++) begin
         @(negedge clk);
         if (!bus) begin
            if (first < 0) first = k;
            plen++;
         end
      end
   endtask

   task automatic write_slot(input int low_len);
      mst_low = 1'b1;
      wait_cyc(low_len);
      mst_low = 1'b0;
      wait_cyc(140 - low_len);
   endtask

   task automatic write_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) write_slot(v[i] ? 4 : 120);
   endtask

   task automatic read_bit(output bit b);
      mst_low = 1'b1;
      wait_cyc(4);
      mst_low = 1'b0;
      wait_cyc(26);
      b = bus;
      wait_cyc(110);
   endtask

   task automatic read_byte(output logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         bit b;
         read_bit(b);
         v[i] = b;
      end
   endtask

   task automatic full_reset(input string tag);
      int f, pl;
      bus_reset(RST_T + 40, f, pl);
      check({tag, " presence length"}, 32'(pl), 32'(PL_T));
      check({tag, " presence delay in window"}, 32'((f >= PW_T) && (f <= PW_T + SYNC + 3)), 32'd1);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #(190000 * 5);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL R1 watchdog expired got=running exp=finished");
         report();
         $finish;
      end
   end

   initial begin
      int f, pl;
      logic [7:0] b0, b1;
      bit rb;
      int ones;

      wait_cyc(4);
      check("R1 reset dq_pull", 32'(dq_pull), 32'd0);
      check("R1 reset commit_stb", 32'(commit_stb), 32'd0);
      check("R1 reset cfg_val", 32'(cfg_val), 32'(RV));
      rst_n = 1'b1;
      wait_cyc(10);
      check("R1 after release cfg_val", 32'(cfg_val), 32'(RV));

      // R2: too short a low gives no presence
      bus_reset(RST_T - 40, f, pl);
      check("R2 short low no presence", 32'(pl), 32'd0);
      // R2, R3: long low gives presence
      full_reset("R2 R3");

      // R6, R5: store two bytes
      write_byte(8'h01);
      write_byte(8'h5E);
      write_byte(8'hC3);
      wait_cyc(4);
      check("R6 R5 stored cfg_val", 32'(cfg_val), 32'h0000C35E);

      // R7: fetch, then R12: extra slots silent
      full_reset("R7");
      write_byte(8'h02);
      read_byte(b0);
      read_byte(b1);
      check("R7 R5 fetched byte0", 32'(b0), 32'h5E);
      check("R7 fetched byte1", 32'(b1), 32'hC3);
      ones = 0;
      for (int i = 0; i < 8; i++) begin
         read_bit(rb);
         ones += rb;
      end
      check("R12 slots after last byte read as 1", 32'(ones), 32'd8);
      write_byte(8'h00);
      check("R12 cfg_val unchanged after extra writes", 32'(cfg_val), 32'h0000C35E);

      // R8: commit strobe
      full_reset("R8");
      write_byte(8'h48);
      wait_cyc(10);
      check("R8 commit pulse count", 32'(n_commit), 32'd1);
      check("R8 cfg_val at commit", 32'(cfg_at_commit), 32'h0000C35E);

      // R9: recall
      full_reset("R9");
      write_byte(8'hB8);
      wait_cyc(4);
      check("R9 recalled cfg_val", 32'(cfg_val), 32'(SV));

      // R10: unknown command
      full_reset("R10");
      write_byte(8'h77);
      write_byte(8'h01);
      write_byte(8'h00);
      write_byte(8'h00);
      check("R10 cfg_val unchanged", 32'(cfg_val), 32'(SV));
      ones = 0;
      for (int i = 0; i < 8; i++) begin
         read_bit(rb);
         ones += rb;
      end
      check("R10 read slots give 1", 32'(ones), 32'd8);
      check("R10 no extra commit", 32'(n_commit), 32'd1);

      // R4: sample point, low just before it reads 1, just after reads 0
      full_reset("R4");
      write_byte(8'h01);
      for (int i = 0; i < 8; i++) write_slot(SMP_T - 8);
      for (int i = 0; i < 8; i++) write_slot(SMP_T + SYNC + 4);
      wait_cyc(4);
      check("R4 sample point boundary", 32'(cfg_val), 32'h000000FF);

      // R11: reset mid byte aborts
      full_reset("R11");
      write_byte(8'h01);
      write_byte(8'h11);
      for (int i = 0; i < 4; i++) write_slot(120);
      full_reset("R11 abort");
      check("R11 completed byte kept", 32'(cfg_val), 32'h00000011);
      write_byte(8'h02);
      read_byte(b0);
      read_byte(b1);
      check("R11 fetched byte0", 32'(b0), 32'h11);
      check("R11 partial byte dropped", 32'(b1), 32'h00);

      wait_cyc(20);
      done = 1'b1;
      report();
      $finish;
   end

endmodule